// File: doc/BRIEF.md
# Aliased Scalar/Vector Floating-Point Register File

This block is a bank of wide vector registers whose lower half also serves as the scalar floating-point register set. The same flops are seen through three windows: a full-width vector port, a double-width scalar port, and two single-word write ports. The single-word ports touch only the low word or only the high word of the scalar half of an entry. Every write lands on the rising clock edge. Every read is a combinational lookup of the stored contents.

A mode input chooses how the scalar port treats a double-width value. In wide mode, scalar register r is simply the low double-width slice of entry r. In paired mode, a double-width value lives in the low words of an even/odd pair of entries. An odd index is then illegal and raises an error flag. When several write ports hit the same bits in one cycle, a fixed priority decides which one wins, and that priority is applied bit by bit.

Top module: `fpvec_regfile`

## Requirements
- R1: After reset every bit of every entry reads as zero on the vector port, including the bits above the scalar half.
- R2: A vector write replaces the whole entry, and from the next cycle the vector port returns the whole entry for its read address.
- R3: With `pair_mode`=0, the scalar port reads bits 63:0 of entry `sc_raddr`. A scalar write updates bits 63:0 of entry `sc_waddr` and leaves bits 127:64 unchanged.
- R4: A low-word write changes only bits 31:0 of the addressed entry.
- R5: A high-word write changes only bits 63:32 of the addressed entry.
- R6: With `pair_mode`=1, a scalar write to even index r stores `sc_wdata[31:0]` into bits 31:0 of entry r and `sc_wdata[63:32]` into bits 31:0 of entry r+1. All other bits of both entries keep their values.
- R7: With `pair_mode`=1 and an even `sc_raddr` r, `sc_rdata` is {entry r+1 bits 31:0, entry r bits 31:0}.
- R8: With `pair_mode`=1, `sc_err` is 1 when `sc_re` is set with an odd `sc_raddr`, or when `sc_we` is set with an odd `sc_waddr`. Such a write changes no entry, and such a read returns zero. With `pair_mode`=0, `sc_err` is always 0.
- R9: Writes that hit the same bits in one cycle are resolved bit by bit. The vector write beats the scalar write, and the scalar write beats the word writes. Low-word and high-word writes to one entry both take effect.
- R10: A read in the same cycle as a write to the same entry returns the value held before that write.
- R11: In a cycle with no write enable set, no entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pair_mode | input | 1 | 0: wide scalar mode; 1: paired-word mode |
| vec_we | input | 1 | Vector write enable |
| vec_waddr | input | 5 | Vector write index |
| vec_wdata | input | 128 | Vector write data |
| vec_raddr | input | 5 | Vector read index |
| vec_rdata | output | 128 | Vector read data |
| sc_we | input | 1 | Scalar write enable |
| sc_waddr | input | 5 | Scalar write index |
| sc_wdata | input | 64 | Scalar write data |
| sc_re | input | 1 | Scalar read qualifier, used for error reporting |
| sc_raddr | input | 5 | Scalar read index |
| sc_rdata | output | 64 | Scalar read data |
| sc_err | output | 1 | Illegal odd-index scalar access in paired mode |
| lo_we | input | 1 | Low-word write enable |
| lo_waddr | input | 5 | Low-word write index |
| lo_wdata | input | 32 | Low-word write data |
| hi_we | input | 1 | High-word write enable |
| hi_waddr | input | 5 | High-word write index |
| hi_wdata | input | 32 | High-word write data |

## Verification
The bench builds the block with its default parameters: 32 entries of 128 bits over 32-bit words. With these values, both the first and the last entry can be written. That puts the top even/odd pair (30 and 31) within reach, along with the full 64-bit upper slice that only the vector port can see. Because the word width is 32, low-word, high-word and paired-scalar writes can be aimed at the same entry in one cycle. This lets the bench check the per-bit priority, and the case where a paired scalar write and a high-word write split one entry between them.

// File: rtl/fprf_pkg.sv
package fprf_pkg;
  typedef enum logic {
    MODE_WIDE   = 1'b0,
    MODE_PAIRED = 1'b1
  } rf_mode_e;

  localparam int unsigned DEF_REGS   = 32;
  localparam int unsigned DEF_VEC_W  = 128;
  localparam int unsigned DEF_WORD_W = 32;
endpackage

// File: rtl/fprf_wr_decode.sv
module fprf_wr_decode
  import fprf_pkg::*;
#(
  parameter int unsigned NUM_REGS = DEF_REGS,
  parameter int unsigned AW       = $clog2(DEF_REGS)
) (
  input  logic                pair_mode,
  input  logic                vec_we,
  input  logic [AW-1:0]       vec_waddr,
  input  logic                sc_we,
  input  logic [AW-1:0]       sc_waddr,
  input  logic                lo_we,
  input  logic [AW-1:0]       lo_waddr,
  input  logic                hi_we,
  input  logic [AW-1:0]       hi_waddr,
  output logic [NUM_REGS-1:0] vec_hit,
  output logic [NUM_REGS-1:0] sc_lo_hit,
  output logic [NUM_REGS-1:0] sc_hi_hit,
  output logic [NUM_REGS-1:0] lo_hit,
  output logic [NUM_REGS-1:0] hi_hit,
  output logic                wr_illegal
);
  rf_mode_e mode;
  logic     sc_ok;

  assign mode       = rf_mode_e'(pair_mode);
  assign wr_illegal = sc_we && (mode == MODE_PAIRED) && sc_waddr[0];
  assign sc_ok      = sc_we && !wr_illegal;

  // True when an index names the same even/odd pair as a register index.
  function automatic logic same_pair(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return a[AW-1:1] == b[AW-1:1];
  endfunction

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
    localparam logic [AW-1:0] IDX = AW'(i);
    assign vec_hit[i] = vec_we && (vec_waddr == IDX);
    assign lo_hit[i]  = lo_we  && (lo_waddr  == IDX);
    assign hi_hit[i]  = hi_we  && (hi_waddr  == IDX);
    always_comb begin
      if (mode == MODE_PAIRED) begin
        sc_lo_hit[i] = sc_ok && same_pair(sc_waddr, IDX);
        sc_hi_hit[i] = 1'b0;
      end else begin
        sc_lo_hit[i] = sc_ok && (sc_waddr == IDX);
        sc_hi_hit[i] = sc_ok && (sc_waddr == IDX);
      end
    end
  end
endmodule

// File: rtl/fprf_entry.sv
module fprf_entry
  import fprf_pkg::*;
#(
  parameter int unsigned VEC_W  = DEF_VEC_W,
  parameter int unsigned WORD_W = DEF_WORD_W,
  parameter bit          IS_ODD = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pair_mode,
  input  logic                vec_hit,
  input  logic [VEC_W-1:0]    vec_wdata,
  input  logic                sc_lo_hit,
  input  logic                sc_hi_hit,
  input  logic [2*WORD_W-1:0] sc_wdata,
  input  logic                lo_hit,
  input  logic [WORD_W-1:0]   lo_wdata,
  input  logic                hi_hit,
  input  logic [WORD_W-1:0]   hi_wdata,
  output logic [VEC_W-1:0]    q,
  output logic                wr_any
);
  localparam int unsigned SC_W = 2 * WORD_W;

  logic [VEC_W-1:0]  d;
  logic [WORD_W-1:0] sc_lo_word;

  // Replace one word lane (0 = low, 1 = high) of the scalar half.
  function automatic logic [VEC_W-1:0] put_word(input logic [VEC_W-1:0] v,
                                                input logic lane,
                                                input logic [WORD_W-1:0] w);
    logic [VEC_W-1:0] r;
    r = v;
    if (lane) r[SC_W-1:WORD_W] = w;
    else      r[WORD_W-1:0]    = w;
    return r;
  endfunction

  // In paired mode the odd entry of a pair takes the upper half of the value.
  assign sc_lo_word = (rf_mode_e'(pair_mode) == MODE_PAIRED && IS_ODD)
                      ? sc_wdata[SC_W-1:WORD_W] : sc_wdata[WORD_W-1:0];

  assign wr_any = vec_hit | sc_lo_hit | sc_hi_hit | lo_hit | hi_hit;

  // Later assignments override earlier ones: lowest priority first.
  always_comb begin
    d = q;
    if (lo_hit)    d = put_word(d, 1'b0, lo_wdata);
    if (hi_hit)    d = put_word(d, 1'b1, hi_wdata);
    if (sc_lo_hit) d = put_word(d, 1'b0, sc_lo_word);
    if (sc_hi_hit) d = put_word(d, 1'b1, sc_wdata[SC_W-1:WORD_W]);
    if (vec_hit)   d = vec_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (wr_any) q <= d;
  end
endmodule

// File: rtl/fprf_read_view.sv
module fprf_read_view
  import fprf_pkg::*;
#(
  parameter int unsigned NUM_REGS = DEF_REGS,
  parameter int unsigned VEC_W    = DEF_VEC_W,
  parameter int unsigned WORD_W   = DEF_WORD_W,
  parameter int unsigned AW       = $clog2(DEF_REGS)
) (
  input  logic [NUM_REGS-1:0][VEC_W-1:0] mem,
  input  logic                           pair_mode,
  input  logic [AW-1:0]                  vec_raddr,
  input  logic [AW-1:0]                  sc_raddr,
  output logic [VEC_W-1:0]               vec_rdata,
  output logic [2*WORD_W-1:0]            sc_rdata,
  output logic                           rd_illegal
);
  localparam int unsigned SC_W = 2 * WORD_W;

  rf_mode_e      mode;
  logic [AW-1:0] even_idx;
  logic [AW-1:0] odd_idx;

  // Join two low words into one double-width scalar value.
  function automatic logic [SC_W-1:0] join_pair(input logic [VEC_W-1:0] upper,
                                                input logic [VEC_W-1:0] lower);
    return {upper[WORD_W-1:0], lower[WORD_W-1:0]};
  endfunction

  assign mode       = rf_mode_e'(pair_mode);
  assign even_idx   = {sc_raddr[AW-1:1], 1'b0};
  assign odd_idx    = {sc_raddr[AW-1:1], 1'b1};
  assign rd_illegal = (mode == MODE_PAIRED) && sc_raddr[0];
  assign vec_rdata  = mem[vec_raddr];

  always_comb begin
    if (rd_illegal)                sc_rdata = '0;
    else if (mode == MODE_PAIRED)  sc_rdata = join_pair(mem[odd_idx], mem[even_idx]);
    else                           sc_rdata = mem[sc_raddr][SC_W-1:0];
  end
endmodule

// File: rtl/fpvec_regfile.sv
module fpvec_regfile
  import fprf_pkg::*;
#(
  parameter int unsigned NUM_REGS = DEF_REGS,
  parameter int unsigned VEC_W    = DEF_VEC_W,
  parameter int unsigned WORD_W   = DEF_WORD_W,
  localparam int unsigned AW      = $clog2(NUM_REGS),
  localparam int unsigned SC_W    = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pair_mode,
  input  logic              vec_we,
  input  logic [AW-1:0]     vec_waddr,
  input  logic [VEC_W-1:0]  vec_wdata,
  input  logic [AW-1:0]     vec_raddr,
  output logic [VEC_W-1:0]  vec_rdata,
  input  logic              sc_we,
  input  logic [AW-1:0]     sc_waddr,
  input  logic [SC_W-1:0]   sc_wdata,
  input  logic              sc_re,
  input  logic [AW-1:0]     sc_raddr,
  output logic [SC_W-1:0]   sc_rdata,
  output logic              sc_err,
  input  logic              lo_we,
  input  logic [AW-1:0]     lo_waddr,
  input  logic [WORD_W-1:0] lo_wdata,
  input  logic              hi_we,
  input  logic [AW-1:0]     hi_waddr,
  input  logic [WORD_W-1:0] hi_wdata
);
  logic [NUM_REGS-1:0]            vec_hit;
  logic [NUM_REGS-1:0]            sc_lo_hit;
  logic [NUM_REGS-1:0]            sc_hi_hit;
  logic [NUM_REGS-1:0]            lo_hit;
  logic [NUM_REGS-1:0]            hi_hit;
  logic [NUM_REGS-1:0]            entry_wr;
  logic [NUM_REGS-1:0][VEC_W-1:0] mem;
  logic                           wr_illegal;
  logic                           rd_illegal;
  logic                           any_we;

  fprf_wr_decode #(.NUM_REGS(NUM_REGS), .AW(AW)) u_dec (
    .pair_mode (pair_mode),
    .vec_we    (vec_we),
    .vec_waddr (vec_waddr),
    .sc_we     (sc_we),
    .sc_waddr  (sc_waddr),
    .lo_we     (lo_we),
    .lo_waddr  (lo_waddr),
    .hi_we     (hi_we),
    .hi_waddr  (hi_waddr),
    .vec_hit   (vec_hit),
    .sc_lo_hit (sc_lo_hit),
    .sc_hi_hit (sc_hi_hit),
    .lo_hit    (lo_hit),
    .hi_hit    (hi_hit),
    .wr_illegal(wr_illegal)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent
    fprf_entry #(.VEC_W(VEC_W), .WORD_W(WORD_W), .IS_ODD(i % 2 == 1)) u_ent (
      .clk      (clk),
      .rst_n    (rst_n),
      .pair_mode(pair_mode),
      .vec_hit  (vec_hit[i]),
      .vec_wdata(vec_wdata),
      .sc_lo_hit(sc_lo_hit[i]),
      .sc_hi_hit(sc_hi_hit[i]),
      .sc_wdata (sc_wdata),
      .lo_hit   (lo_hit[i]),
      .lo_wdata (lo_wdata),
      .hi_hit   (hi_hit[i]),
      .hi_wdata (hi_wdata),
      .q        (mem[i]),
      .wr_any   (entry_wr[i])
    );
  end

  fprf_read_view #(.NUM_REGS(NUM_REGS), .VEC_W(VEC_W), .WORD_W(WORD_W), .AW(AW)) u_rd (
    .mem       (mem),
    .pair_mode (pair_mode),
    .vec_raddr (vec_raddr),
    .sc_raddr  (sc_raddr),
    .vec_rdata (vec_rdata),
    .sc_rdata  (sc_rdata),
    .rd_illegal(rd_illegal)
  );

  assign any_we = |entry_wr;
  assign sc_err = wr_illegal | (sc_re & rd_illegal);
endmodule

// File: rtl/fprf_chk.sv
module fprf_chk #(
  parameter int unsigned VEC_W  = 128,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned AW     = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                pair_mode,
  input logic                vec_we,
  input logic [AW-1:0]       vec_waddr,
  input logic [VEC_W-1:0]    vec_wdata,
  input logic [AW-1:0]       vec_raddr,
  input logic [VEC_W-1:0]    vec_rdata,
  input logic                sc_re,
  input logic [AW-1:0]       sc_raddr,
  input logic [2*WORD_W-1:0] sc_rdata,
  input logic                sc_err,
  input logic                any_we
);
  logic live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  assert_vec_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(vec_we) && (vec_raddr == $past(vec_waddr)) |-> vec_rdata == $past(vec_wdata));

  assert_wide_alias_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_mode && (sc_raddr == vec_raddr) |-> sc_rdata == vec_rdata[2*WORD_W-1:0]);

  assert_pair_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pair_mode && !sc_raddr[0] && (vec_raddr == {sc_raddr[AW-1:1], 1'b1})
    |-> sc_rdata[2*WORD_W-1:WORD_W] == vec_rdata[WORD_W-1:0]);

  assert_odd_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pair_mode && sc_re && sc_raddr[0] |-> sc_err);

  assert_wide_no_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_mode |-> !sc_err);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    live && !$past(any_we) && $stable(vec_raddr) |-> $stable(vec_rdata));
endmodule

bind fpvec_regfile fprf_chk #(.VEC_W(VEC_W), .WORD_W(WORD_W), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pair_mode(pair_mode),
  .vec_we   (vec_we),
  .vec_waddr(vec_waddr),
  .vec_wdata(vec_wdata),
  .vec_raddr(vec_raddr),
  .vec_rdata(vec_rdata),
  .sc_re    (sc_re),
  .sc_raddr (sc_raddr),
  .sc_rdata (sc_rdata),
  .sc_err   (sc_err),
  .any_we   (any_we)
);

// File: tb/fpvec_regfile_bench.sv
`timescale 1ns/100ps
module fpvec_regfile_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pair_mode = 1'b0;
  logic         vec_we = 1'b0;
  logic [4:0]   vec_waddr = '0;
  logic [127:0] vec_wdata = '0;
  logic [4:0]   vec_raddr = '0;
  logic [127:0] vec_rdata;
  logic         sc_we = 1'b0;
  logic [4:0]   sc_waddr = '0;
  logic [63:0]  sc_wdata = '0;
  logic         sc_re = 1'b0;
  logic [4:0]   sc_raddr = '0;
  logic [63:0]  sc_rdata;
  logic         sc_err;
  logic         lo_we = 1'b0;
  logic [4:0]   lo_waddr = '0;
  logic [31:0]  lo_wdata = '0;
  logic         hi_we = 1'b0;
  logic [4:0]   hi_waddr = '0;
  logic [31:0]  hi_wdata = '0;

  always #2 clk = ~clk;

  fpvec_regfile u_fpvec_regfile (.*);

  typedef struct {
    int           kind;   // 0 vector data, 1 scalar data, 2 error flag
    logic [127:0] exp;
    string        req;
  } item_t;

  item_t        sb[$];
  event         chk_ev;
  int           n_chk = 0;
  int           n_fail = 0;
  bit           done = 1'b0;
  logic [127:0] mdl [32];

  // Monitor: pops expected items and compares against the ports.
  initial forever begin
    @(chk_ev);
    while (sb.size() > 0) begin
      item_t it;
      logic [127:0] act;
      it = sb.pop_front();
      case (it.kind)
        0:       act = vec_rdata;
        1:       act = {64'h0, sc_rdata};
        default: act = {127'h0, sc_err};
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic push(input int kind, input logic [127:0] exp, input string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    #0.2;
    sb.push_back(it);
    -> chk_ev;
    #0.2;
  endtask

  task automatic chk_vec(input int a, input string req);
    vec_raddr = 5'(a);
    push(0, mdl[a], req);
  endtask

  task automatic chk_sc(input int a, input string req);
    logic [63:0] e;
    sc_raddr = 5'(a);
    if (pair_mode && a[0])  e = '0;
    else if (pair_mode)     e = {mdl[a + 1][31:0], mdl[a][31:0]};
    else                    e = mdl[a][63:0];
    push(1, {64'h0, e}, req);
  endtask

  task automatic chk_err(input logic exp, input string req);
    push(2, {127'h0, exp}, req);
  endtask

  // Bench model of one clock edge: lowest-priority writes applied first.
  task automatic commit();
    logic [127:0] n [32];
    for (int i = 0; i < 32; i++) n[i] = mdl[i];
    if (lo_we) n[lo_waddr][31:0]  = lo_wdata;
    if (hi_we) n[hi_waddr][63:32] = hi_wdata;
    if (sc_we) begin
      if (!pair_mode) n[sc_waddr][63:0] = sc_wdata;
      else if (!sc_waddr[0]) begin
        n[sc_waddr][31:0]     = sc_wdata[31:0];
        n[sc_waddr + 1][31:0] = sc_wdata[63:32];
      end
    end
    if (vec_we) n[vec_waddr] = vec_wdata;
    @(posedge clk);
    for (int i = 0; i < 32; i++) mdl[i] = n[i];
    @(negedge clk);
    vec_we = 1'b0; sc_we = 1'b0; lo_we = 1'b0; hi_we = 1'b0;
  endtask

  task automatic wr_vec(input int a, input logic [127:0] d);
    vec_we = 1'b1; vec_waddr = 5'(a); vec_wdata = d; commit();
  endtask
  task automatic wr_sc(input int a, input logic [63:0] d);
    sc_we = 1'b1; sc_waddr = 5'(a); sc_wdata = d; commit();
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: all entries zero, including upper bits
    for (int i = 0; i < 32; i++) chk_vec(i, "R1");
    chk_sc(31, "R1");

    // R2: whole-entry vector writes at both ends
    wr_vec(3, 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210);
    chk_vec(3, "R2");
    wr_vec(31, 128'hdead_beef_0000_1111_2222_3333_4444_5555);
    chk_vec(31, "R2");
    chk_vec(30, "R2");

    // R3: wide scalar write keeps upper 64 bits
    wr_sc(3, 64'haaaa_bbbb_cccc_dddd);
    chk_vec(3, "R3");
    chk_sc(3, "R3");

    // R4 and R5: word writes
    lo_we = 1'b1; lo_waddr = 5'd3; lo_wdata = 32'h1357_9bdf; commit();
    chk_vec(3, "R4");
    hi_we = 1'b1; hi_waddr = 5'd31; hi_wdata = 32'h2468_ace0; commit();
    chk_vec(31, "R5");

    // R10: same-cycle read sees old value, then new
    vec_we = 1'b1; vec_waddr = 5'd5; vec_wdata = {4{32'h5a5a_a5a5}};
    vec_raddr = 5'd5;
    chk_vec(5, "R10");
    commit();
    chk_vec(5, "R10");

    // R9: vector beats scalar beats words on entry 7
    vec_we = 1'b1; vec_waddr = 5'd7; vec_wdata = {4{32'h7777_0000}};
    sc_we  = 1'b1; sc_waddr  = 5'd7; sc_wdata  = 64'h1111_2222_3333_4444;
    lo_we  = 1'b1; lo_waddr  = 5'd7; lo_wdata  = 32'h5555_6666;
    hi_we  = 1'b1; hi_waddr  = 5'd7; hi_wdata  = 32'h7777_8888;
    commit();
    chk_vec(7, "R9");
    // R9: scalar beats words on entry 8
    sc_we = 1'b1; sc_waddr = 5'd8; sc_wdata = 64'h0808_0808_8080_8080;
    lo_we = 1'b1; lo_waddr = 5'd8; lo_wdata = 32'hffff_ffff;
    hi_we = 1'b1; hi_waddr = 5'd8; hi_wdata = 32'heeee_eeee;
    commit();
    chk_vec(8, "R9");
    // R9: low and high to one entry both land
    lo_we = 1'b1; lo_waddr = 5'd9; lo_wdata = 32'h0909_0001;
    hi_we = 1'b1; hi_waddr = 5'd9; hi_wdata = 32'h0909_0002;
    commit();
    chk_vec(9, "R9");

    // R6 and R7: paired mode
    wr_vec(12, {4{32'hc0c0_c0c0}});
    wr_vec(13, {4{32'hd1d1_d1d1}});
    pair_mode = 1'b1;
    wr_sc(12, 64'h1313_1313_1212_1212);
    chk_vec(12, "R6");
    chk_vec(13, "R6");
    chk_sc(12, "R7");
    wr_sc(30, 64'h3131_0000_3030_ffff);
    chk_vec(31, "R6");
    chk_sc(30, "R7");
    // R9: paired scalar low word and high-word port split entry 11
    sc_we = 1'b1; sc_waddr = 5'd10; sc_wdata = 64'h0b0b_0b0b_0a0a_0a0a;
    hi_we = 1'b1; hi_waddr = 5'd11; hi_wdata = 32'hbbbb_1111;
    commit();
    chk_vec(11, "R9");
    chk_sc(10, "R7");

    // R8: odd index in paired mode
    sc_re = 1'b1; sc_raddr = 5'd13;
    chk_err(1'b1, "R8");
    chk_sc(13, "R8");
    sc_re = 1'b0; sc_raddr = 5'd12;
    sc_we = 1'b1; sc_waddr = 5'd13; sc_wdata = 64'hffff_ffff_ffff_ffff;
    chk_err(1'b1, "R8");
    commit();
    chk_vec(13, "R8");
    chk_vec(14, "R8");
    pair_mode = 1'b0;
    sc_re = 1'b1; sc_raddr = 5'd13;
    chk_err(1'b0, "R8");
    chk_sc(13, "R3");
    sc_re = 1'b0;

    // R11: idle cycles hold contents
    repeat (4) @(negedge clk);
    chk_vec(3, "R11");
    chk_vec(31, "R11");

    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule